// File: doc/BRIEF.md
# Single-Wire Debug Host Bit Receiver

This block is the host end of a read on a bidirectional single-wire debug line. The line is open-drain with a pull-up. A request opens a bit time: the block pulls the line low for a short, fixed number of cycles to create the falling edge the target needs. It then lets go of the line, well before the target may drive its brief active-high speed-up pulse. Next it samples the line at a fixed offset from the bit start. That offset leaves room for the target seeing the edge up to one cycle late.

The line input is asynchronous. It goes through a synchronizer chain, and the capture point is shifted by the chain's latency, so the sampled value is the one the line had at the nominal sample cycle. The received bit is presented with a one-cycle valid pulse. The block accepts no new request until a guard interval after the bit start has passed, so the target can finish the bit before the next one opens.

The request side is a valid/ready pair. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, `req_valid` is ignored and may be held high without effect, so a held request starts the next bit as soon as the guard interval ends. The result side has no back-pressure: `rx_valid` is high for exactly one cycle, and the consumer must take `rx_bit` in that cycle. `rx_bit` keeps its value until the next result.

Top module: `dbgrx_bit_receiver`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `line_oe` (1 = pull the line low) rises in the cycle after that edge, and this cycle is bit cycle 0.
- R2: `line_oe` is high in bit cycles 0, 1 and 2 (LOW_CYCLES = 3) and low from bit cycle 3 onward, so the line is released well before the target's speed-up pulse, which may start in cycle 7.
- R3: The received bit equals the level that `line_in` had during bit cycle 10. A level on `line_in` during bit cycle 9 or 11 alone has no effect on the result.
- R4: `rx_valid` is high in bit cycle 13 only, and for exactly one cycle (sample cycle plus two synchronizer stages plus one output register). `rx_bit` holds the received value from then until the next result.
- R5: `req_ready` is low in bit cycles 0 to 15 and high again from cycle 16. A `req_valid` pulse while `req_ready` is low is ignored and starts no bit time.
- R6: After reset, `line_oe` = 0, `req_ready` = 1, `rx_valid` = 0 and `rx_bit` = 0.
- R7: A target that sees the bit start 0 or 1 cycle late and holds the line low for 13 cycles reads as 0. A target that leaves the line released reads as 1.
- R8: If `req_valid` stays high, the next bit starts in cycle 17 of the current bit: `req_ready` is high in cycle 16 and the request is accepted at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, equal to the target's bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request to read one bit |
| req_ready | output | 1 | Block can accept a request |
| line_oe | output | 1 | 1 = drive the line low, 0 = release it |
| line_in | input | 1 | Asynchronous level of the line |
| rx_bit | output | 1 | Last received bit |
| rx_valid | output | 1 | One-cycle pulse when `rx_bit` is new |

## Verification
On every cycle the assertions check the following. A rise of `line_oe` always follows an accepted request. The drive always ends after exactly the programmed low time. The line is never still driven when the capture happens. `rx_valid` never lasts more than one cycle. `req_ready` only returns at the end of the guard count. Only the bench scenarios can show the exact sample cycle, by placing a one-cycle low pulse in cycles 9, 10 and 11. The same holds for skew tolerance with a target model that is 0 or 1 cycle late, for a request ignored while busy, and for the cycle-17 restart under a held request.

// File: rtl/dbgrx_pkg.sv
package dbgrx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/dbgrx_sync.sv
// Multi-stage synchronizer for the asynchronous line level.
module dbgrx_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RESET_VAL;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= RESET_VAL;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dbgrx_seq.sv
// Bit-time sequencer: opens the bit, times the drive, capture and guard.
module dbgrx_seq
  import dbgrx_pkg::*;
#(
  parameter int LOW_CYCLES   = 3,
  parameter int CAPTURE_AT   = 12,
  parameter int GUARD_CYCLES = 16,
  parameter int CNT_W        = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic drive_low,
  output logic capture
);
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_CYCLES - 1);
  localparam logic [CNT_W-1:0] GUARD_END = CNT_W'(GUARD_CYCLES - 1);
  localparam logic [CNT_W-1:0] CAP_CNT   = CNT_W'(CAPTURE_AT);
  localparam logic [CNT_W-1:0] LOW_DONE  = CNT_W'(LOW_CYCLES);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q <= ST_BUSY;
            cnt_q   <= '0;
            oe_q    <= 1'b1;
          end
        end
        ST_BUSY: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LOW_LAST)  oe_q    <= 1'b0;
          if (cnt_q == GUARD_END) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign drive_low = oe_q;
  assign capture   = (state_q == ST_BUSY) && (cnt_q == CAP_CNT);

  // R1: the drive only starts after an accepted request
  p_start_on_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(req_valid && req_ready));

  // R2: the drive ends exactly after the programmed low time
  p_low_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> (cnt_q == LOW_DONE));

  // R5: ready only returns at the end of the guard count
  p_guard_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> ($past(cnt_q) == GUARD_END));
endmodule

// File: rtl/dbgrx_capture.sv
// Captures the synchronized line level and emits the one-cycle result.
module dbgrx_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic line_sync,
  output logic rx_bit,
  output logic rx_valid
);
  logic bit_q;
  logic vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= capture;
      if (capture) bit_q <= line_sync;
    end
  end

  assign rx_bit   = bit_q;
  assign rx_valid = vld_q;

  // R4: the result strobe lasts a single cycle
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4: the bit is stable whenever no new result is presented
  p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_bit));
endmodule

// File: rtl/dbgrx_bit_receiver.sv
module dbgrx_bit_receiver #(
  parameter int LOW_CYCLES   = 3,
  parameter int SAMPLE_CYCLE = 10,
  parameter int GUARD_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic line_oe,
  input  logic line_in,
  output logic rx_bit,
  output logic rx_valid
);
  localparam int CAPTURE_AT = SAMPLE_CYCLE + SYNC_STAGES;
  localparam int CNT_W      = $clog2(GUARD_CYCLES + 1);

  logic line_sync;
  logic capture;

  dbgrx_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(line_in),
    .q_sync (line_sync)
  );

  dbgrx_seq #(
    .LOW_CYCLES  (LOW_CYCLES),
    .CAPTURE_AT  (CAPTURE_AT),
    .GUARD_CYCLES(GUARD_CYCLES),
    .CNT_W       (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .drive_low(line_oe),
    .capture  (capture)
  );

  dbgrx_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .line_sync(line_sync),
    .rx_bit   (rx_bit),
    .rx_valid (rx_valid)
  );

  // R3: the host never still drives the line when the level is taken
  p_released_at_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !line_oe);

  // R5: a request never opens a bit while the previous one is running
  p_no_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && !$past(line_oe)) |-> !req_ready);
endmodule

// File: tb/dbgrx_bit_receiver_tb.sv
module dbgrx_bit_receiver_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic line_in = 1'b1;
  logic req_ready, line_oe, rx_bit, rx_valid;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbgrx_bit_receiver u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .line_oe(line_oe), .line_in(line_in), .rx_bit(rx_bit), .rx_valid(rx_valid)
  );

  task automatic chk(input string req, input logic act, input logic exp, input int t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, t, act, exp);
    end
  endtask

  // mode 0: target leaves line released; 1: target holds low 13 cycles from skew;
  // 2: one-cycle low pulse at cycle pulse_at only.
  // busy_poke: pulse req_valid at cycle 5; hold: keep req_valid high throughout.
  task automatic run_bit(input string tag, input int mode, input int skew,
                         input int pulse_at, input logic exp_bit,
                         input bit busy_poke, input bit hold);
    bit tlow;
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    for (int t = 0; t <= 20; t++) begin
      // R1 / R2 / R8: drive window
      chk({tag, " R2 line_oe"}, line_oe,
          (t < 3) || (hold && t >= 17 && t < 20), t);
      // R5 / R8: ready window
      chk({tag, " R5 req_ready"}, req_ready, (t >= 16) && !(hold && t >= 17), t);
      // R4: one-cycle valid at cycle 13
      chk({tag, " R4 rx_valid"}, rx_valid, (t == 13), t);
      if (t == 13) chk({tag, " R3 rx_bit"}, rx_bit, exp_bit, t);
      if (t > 13 && t <= 20) chk({tag, " R4 rx_bit hold"}, rx_bit, exp_bit, t);
      tlow = (mode == 1 && t >= skew && t < skew + 13) || (mode == 2 && t == pulse_at);
      line_in = !(line_oe || tlow);
      if (busy_poke) req_valid = (t == 5);
      @(negedge clk);
    end
    req_valid = 1'b0;
    line_in = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R6 line_oe", line_oe, 1'b0, 0);
    chk("R6 req_ready", req_ready, 1'b1, 0);
    chk("R6 rx_valid", rx_valid, 1'b0, 0);
    chk("R6 rx_bit", rx_bit, 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_bit("R7 one",          0, 0, 0,  1'b1, 0, 0);
    run_bit("R7 zero skew0",   1, 0, 0,  1'b0, 0, 0);
    run_bit("R7 zero skew1",   1, 1, 0,  1'b0, 0, 0);
    run_bit("R3 pulse at 10",  2, 0, 10, 1'b0, 0, 0);
    run_bit("R3 pulse at 9",   2, 0, 9,  1'b1, 0, 0);
    run_bit("R3 pulse at 11",  2, 0, 11, 1'b1, 0, 0);
    run_bit("R5 busy request", 1, 0, 0,  1'b0, 1, 0);
    run_bit("R8 held request", 0, 0, 0,  1'b1, 0, 1);
    run_bit("R1 after restart",1, 1, 0,  1'b0, 0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule